// File: doc/BRIEF.md
# QPSK Differential Symbol Modulator

This block turns a stream of two-bit symbols into a signed carrier sample stream. Each accepted dibit is added, through a Gray map, to a running quadrant index. The index therefore carries the change of phase rather than the absolute phase. The quadrant sets the signs of the in-phase and quadrature levels. These are placed on a carrier at exactly one quarter of the sample clock, so that the product I·cos − Q·sin needs no multipliers. Over every four clocks it walks through I, −Q, −I, Q.

A new symbol begins every `SYM_CLKS` clocks. A source offers dibits with a valid/ready handshake and is served once per symbol period. If it has nothing ready at that moment, the current phase is sent again and a one-clock underflow flag is raised. The same module carries the receive-side inverse, which is independent of the transmit path. It takes the quadrant index a demodulator decides for each received symbol, subtracts the previous one modulo 4 and undoes the Gray map. Any constant rotation by a multiple of 90° therefore cancels out after the first symbol.

Top module: `qpsk_diff_mod`

## Requirements
- R1: While reset is low, `sample` is 0, `sym_strobe`, `underflow` and `dec_valid` are 0, and `in_ready` is 1.
- R2: `in_ready` is high only in the last clock of each `SYM_CLKS`-clock symbol period. A dibit is taken only at a clock edge where `in_valid` and `in_ready` are both high. A dibit held on the input at any other time leaves the output unchanged.
- R3: The transmit quadrant index starts at 0 after reset. Each accepted dibit adds an increment modulo 4: 00 adds 0, 01 adds 1, 11 adds 2, 10 adds 3.
- R4: Quadrant index 0 gives levels (I,Q) = (+AMP,+AMP). Index 1 gives (−AMP,+AMP), index 2 gives (−AMP,−AMP) and index 3 gives (+AMP,−AMP). AMP defaults to 127 on an 8-bit signed output.
- R5: In the clock in which `sym_strobe` is high, `sample` equals I of the new symbol. The clocks that follow give −Q, −I, Q, and this four-value pattern repeats until the next strobe.
- R6: `sym_strobe` is high for exactly one clock at the start of each symbol, every `SYM_CLKS` clocks. The first strobe comes on the first symbol boundary after reset is released.
- R7: If `in_valid` is low when `in_ready` is high, the next symbol repeats the previous quadrant index. In that case `underflow` is high for one clock, together with `sym_strobe`.
- R8: One clock after `rx_valid` is high, `dec_valid` is high. `dec_dibit` then holds the inverse Gray map of (`rx_quad` − previous `rx_quad`) modulo 4: difference 0 gives 00, 1 gives 01, 2 gives 11 and 3 gives 10. The previous index is 0 after reset. `dec_valid` is low in any clock that does not follow an `rx_valid`.
- R9: Adding a constant k (0..3) modulo 4 to every received quadrant index leaves every decoded dibit unchanged from the second symbol onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A dibit is offered |
| in_dibit | input | 2 | Dibit to transmit |
| in_ready | output | 1 | Block takes a dibit at this edge if offered |
| sym_strobe | output | 1 | First clock of a new symbol |
| underflow | output | 1 | No dibit was offered at the last symbol boundary |
| sample | output | SAMPLE_W | Signed carrier sample, one per clock |
| rx_valid | input | 1 | A received quadrant index is offered |
| rx_quad | input | 2 | Received quadrant index (0..3) |
| dec_valid | output | 1 | `dec_dibit` holds a decoded dibit |
| dec_dibit | output | 2 | Differentially decoded dibit |

## Verification
The case hardest to reach from the ports is a dibit held on the input between boundaries, which the block must not take. The bench keeps `in_valid` high through every symbol period. It then checks all eight samples of each symbol against the quadrant predicted for one dibit per period. The underflow path is reached twice: once at the first boundary after reset, where nothing is offered yet, and again after the vector walk, when the source stops. Decoder rotation invariance is shown by replaying the transmit quadrant sequence under all four rotations without resetting the receive history.

// File: rtl/qdm_pkg.sv
package qdm_pkg;

  typedef logic [1:0] quad_t;

  // Gray-coded dibit to quadrant increment: 00->0, 01->1, 11->2, 10->3
  function automatic quad_t dibit_to_step(input logic [1:0] d);
    return {d[1], d[1] ^ d[0]};
  endfunction

  // Quadrant difference back to Gray-coded dibit
  function automatic logic [1:0] step_to_dibit(input quad_t s);
    return {s[1], s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/qdm_diff_enc.sv
module qdm_diff_enc
  import qdm_pkg::*;
#(
  parameter int SYM_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_dibit,
  output logic       in_ready,
  output quad_t      phase_next,
  output logic       strobe_o,
  output logic       uflow_o
);

  localparam int CW = (SYM_CLKS > 1) ? $clog2(SYM_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYM_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  quad_t         phase_q, phase_d;
  logic          strobe_q, strobe_d;
  logic          uflow_q, uflow_d;
  logic          boundary, take;

  always_comb begin
    boundary = (cnt_q == LAST);
    take     = boundary & in_valid;
    cnt_d    = boundary ? '0 : cnt_q + CW'(1);
    phase_d  = take ? quad_t'(phase_q + dibit_to_step(in_dibit)) : phase_q;
    strobe_d = boundary;
    uflow_d  = boundary & ~in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= LAST;
      phase_q  <= '0;
      strobe_q <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      phase_q  <= phase_d;
      strobe_q <= strobe_d;
      uflow_q  <= uflow_d;
    end
  end

  assign in_ready   = boundary;
  assign phase_next = phase_d;
  assign strobe_o   = strobe_q;
  assign uflow_o    = uflow_q;

  // R2: a ready clock is never followed directly by another
  a_r2_ready_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R6: the symbol strobe lasts a single clock
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  // R7: an underflow symbol repeats the previous phase
  a_r7_uflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_q |-> (phase_q == $past(phase_q)));

  // R7: underflow only ever marks the start of a symbol
  a_r7_uflow_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_q |-> strobe_q);

endmodule

// File: rtl/qdm_carrier.sv
module qdm_carrier
  import qdm_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  quad_t                      phase_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);

  localparam logic signed [SAMPLE_W-1:0] POS = SAMPLE_W'(AMP);
  localparam logic signed [SAMPLE_W-1:0] NEG = -POS;

  logic [1:0]                 car_q, car_d;
  logic signed [SAMPLE_W-1:0] samp_q, samp_d;
  logic signed [SAMPLE_W-1:0] lvl_i, lvl_q;

  always_comb begin
    lvl_i = (phase_i[1] ^ phase_i[0]) ? NEG : POS;
    lvl_q = phase_i[1] ? NEG : POS;
    car_d = car_q + 2'd1;
    unique case (car_d)
      2'd0: samp_d = lvl_i;
      2'd1: samp_d = -lvl_q;
      2'd2: samp_d = -lvl_i;
      default: samp_d = lvl_q;
    endcase
  end

  // carrier index resets to 3 so the first boundary lands on index 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q  <= 2'd3;
      samp_q <= '0;
    end else begin
      car_q  <= car_d;
      samp_q <= samp_d;
    end
  end

  assign sample_o = samp_q;

  // R5: the second half of each carrier cycle negates the first half
  a_r5_half_cycle_negate: assert property (@(posedge clk) disable iff (!rst_n)
    car_q[1] |-> (samp_q == -$past(samp_q, 2)));

endmodule

// File: rtl/qdm_diff_dec.sv
module qdm_diff_dec
  import qdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  quad_t      rx_quad,
  output logic       dec_valid,
  output logic [1:0] dec_dibit
);

  quad_t      prev_q, prev_d;
  logic       vld_q, vld_d;
  logic [1:0] dib_q, dib_d;

  always_comb begin
    vld_d  = rx_valid;
    prev_d = rx_valid ? rx_quad : prev_q;
    dib_d  = rx_valid ? step_to_dibit(quad_t'(rx_quad - prev_q)) : dib_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
      dib_q  <= '0;
    end else begin
      prev_q <= prev_d;
      vld_q  <= vld_d;
      dib_q  <= dib_d;
    end
  end

  assign dec_valid = vld_q;
  assign dec_dibit = dib_q;

  // R8: an unchanged quadrant decodes to 00
  a_r8_same_quad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_quad == prev_q) |=> (dec_dibit == 2'b00));

  // R8: output valid only after an input valid
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rx_valid));

endmodule

// File: rtl/qpsk_diff_mod.sv
module qpsk_diff_mod
  import qdm_pkg::*;
#(
  parameter int SYM_CLKS = 8,
  parameter int SAMPLE_W = 8,
  parameter int AMP      = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 in_dibit,
  output logic                       in_ready,
  output logic                       sym_strobe,
  output logic                       underflow,
  output logic signed [SAMPLE_W-1:0] sample,
  input  logic                       rx_valid,
  input  logic [1:0]                 rx_quad,
  output logic                       dec_valid,
  output logic [1:0]                 dec_dibit
);

  logic  rst_meta_q, rst_sync_q;
  quad_t phase_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  qdm_diff_enc #(.SYM_CLKS(SYM_CLKS)) enc_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .in_valid  (in_valid),
    .in_dibit  (in_dibit),
    .in_ready  (in_ready),
    .phase_next(phase_next),
    .strobe_o  (sym_strobe),
    .uflow_o   (underflow)
  );

  qdm_carrier #(.SAMPLE_W(SAMPLE_W), .AMP(AMP)) car_i (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .phase_i (phase_next),
    .sample_o(sample)
  );

  qdm_diff_dec dec_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .rx_valid (rx_valid),
    .rx_quad  (rx_quad),
    .dec_valid(dec_valid),
    .dec_dibit(dec_dibit)
  );

endmodule

// File: tb/qpsk_diff_mod_tb_top.sv
module qpsk_diff_mod_tb_top;

  localparam int SYM = 8;
  localparam int AMP = 127;
  localparam int N   = 10;
  // {dibit, expected quadrant after it}, starting from quadrant 0
  localparam logic [3:0] VEC [N] = '{
    4'b00_00, 4'b01_01, 4'b11_11, 4'b10_10, 4'b01_11,
    4'b01_00, 4'b11_10, 4'b00_10, 4'b10_01, 4'b11_11
  };

  logic             clk, rst_n, in_valid, in_ready, sym_strobe, underflow;
  logic [1:0]       in_dibit, rx_quad, dec_dibit;
  logic             rx_valid, dec_valid;
  logic signed [7:0] sample;
  int errors, checks;

  qpsk_diff_mod #(.SYM_CLKS(SYM), .SAMPLE_W(8), .AMP(AMP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dibit(in_dibit),
    .in_ready(in_ready), .sym_strobe(sym_strobe), .underflow(underflow),
    .sample(sample), .rx_valid(rx_valid), .rx_quad(rx_quad),
    .dec_valid(dec_valid), .dec_dibit(dec_dibit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R4/R5 expected level for quadrant q at carrier position j
  function automatic int exp_sample(input logic [1:0] q, input int j);
    int iv, qv;
    iv = (q == 2'd1 || q == 2'd2) ? -AMP : AMP;
    qv = (q[1]) ? -AMP : AMP;
    case (j % 4)
      0: return iv;
      1: return -qv;
      2: return -iv;
      default: return qv;
    endcase
  endfunction

  task automatic check_reset(input string tag);
    chk({tag, " R1 sample"}, int'(sample), 0);
    chk({tag, " R1 strobe"}, int'(sym_strobe), 0);
    chk({tag, " R1 underflow"}, int'(underflow), 0);
    chk({tag, " R1 ready"}, int'(in_ready), 1);
    chk({tag, " R1 dec_valid"}, int'(dec_valid), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    errors = 0; checks = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_dibit = 2'b00;
    rx_valid = 1'b0; rx_quad = 2'b00;
    repeat (3) @(negedge clk);
    check_reset("initial");
    rst_n = 1'b1;

    // R7/R6: first boundary after reset with nothing offered
    while (!sym_strobe) @(negedge clk);
    chk("R7 first underflow", int'(underflow), 1);
    chk("R4 first sample quadrant 0", int'(sample), AMP);
    @(negedge clk);
    chk("R7 underflow one clock", int'(underflow), 0);

    // vector walk: one dibit per symbol, input held valid all the time
    for (int v = 0; v < N; v++) begin
      in_valid = 1'b1;
      in_dibit = VEC[v][3:2];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      chk($sformatf("R6 strobe v%0d", v), int'(sym_strobe), 1);
      chk($sformatf("R7 no underflow v%0d", v), int'(underflow), 0);
      for (int j = 0; j < SYM; j++) begin
        if (j > 0) @(negedge clk);
        chk($sformatf("R3 R5 sample v%0d j%0d", v, j), int'(sample),
            exp_sample(VEC[v][1:0], j));
        if (j > 0) chk($sformatf("R6 strobe low v%0d j%0d", v, j), int'(sym_strobe), 0);
        chk($sformatf("R2 ready v%0d j%0d", v, j), int'(in_ready), (j == SYM-1) ? 1 : 0);
      end
    end

    // R7: source goes quiet, last phase (quadrant 3) repeats
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk("R7 underflow set", int'(underflow), 1);
    chk("R6 strobe with underflow", int'(sym_strobe), 1);
    for (int j = 0; j < 4; j++) begin
      if (j > 0) @(negedge clk);
      chk($sformatf("R7 held phase j%0d", j), int'(sample), exp_sample(2'd3, j));
    end
    chk("R7 underflow cleared", int'(underflow), 0);

    // R8/R9: decode the transmit quadrant sequence under four rotations
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < N; v++) begin
        rx_valid = 1'b1;
        rx_quad  = VEC[v][1:0] + 2'(k);
        @(negedge clk);
        chk($sformatf("R8 dec_valid k%0d v%0d", k, v), int'(dec_valid), 1);
        if (v > 0 || k == 0)
          chk($sformatf("R9 dibit k%0d v%0d", k, v), int'(dec_dibit), int'(VEC[v][3:2]));
      end
      rx_valid = 1'b0;
      @(negedge clk);
      chk($sformatf("R8 dec_valid low k%0d", k), int'(dec_valid), 0);
    end

    // R1: reset in the middle of operation
    in_valid = 1'b1;
    rst_n = 1'b0;
    #1;
    check_reset("mid-run");
    @(negedge clk);
    in_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule